// File: doc/BRIEF.md
# Coarse-Fine Hit Timestamp Composer

This block turns a detector hit into one binary time word by stacking three levels of fine time under a free-running coarse count. The coarse counter steps once per reference clock cycle (40 MHz, 25 ns per step). Below it sit three finer fields:

- a 3-bit phase index taken from a clock eight times faster (3.125 ns steps);
- a 5-bit tap index decoded from a sampled 32-cell delay-line thermometer vector (about 98 ps per tap);
- an optional 2-bit interpolation field that splits each tap into four (about 25 ps per step).

The analog clock multiplier, the delay line and the interpolators sit outside the block. The block sees their sampled outputs as plain vectors.

A hit is presented as a one-cycle strobe together with a channel number, the resolution mode and the sampled fine vectors. In low-resolution mode all 32 channels are accepted and the interpolation field is cleared. In high-resolution mode only channels 0 to 7 are accepted and the interpolation bits are kept. An accepted hit produces one valid cycle on the output, one clock after the strobe. That cycle carries the time word, the channel and a flag giving the mode in force at the hit.

Top module: `tdc_stamp_top`

## Requirements
- R1: The coarse field `stamp[21:10]` holds the value the 12-bit coarse counter had in the cycle of the strobe. The counter starts at 0 after reset and increases by one every clock.
- R2: The phase field `stamp[9:7]` equals `phaseIdx` as sampled with the strobe.
- R3: The tap field `stamp[6:2]` equals the index of the lowest 0 bit of `tapVec`. Bit 0 is the start of the line. With `tapVec` all ones it reads 31, and with bit 0 clear it reads 0.
- R4: Bubble tolerance: any 1 bits above the lowest 0 of `tapVec` have no effect on the tap field.
- R5: In low-resolution mode (`hiResMode`=0) the interpolation field `stamp[1:0]` is 0 whatever `interpBits` carries, and `stampHiRes` is 0.
- R6: In high-resolution mode (`hiResMode`=1) `stamp[1:0]` equals `interpBits` and `stampHiRes` is 1.
- R7: In high-resolution mode a strobe on a channel of 8 or above is ignored. No valid cycle follows, and `stamp`, `stampChan` and `stampHiRes` keep their previous values.
- R8: In low-resolution mode a strobe on any channel 0 to 31 is accepted, and `stampChan` reports that channel.
- R9: `stampValid` is high for exactly one cycle, the cycle after an accepted strobe, and is low otherwise.
- R10: The coarse counter wraps from 4095 to 0. A strobe in the cycle where the counter holds 4095 is stamped 4095, and a strobe in the next cycle is stamped 0.
- R11: While reset is held, `stampValid` is 0 and `stamp`, `stampChan` and `stampHiRes` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the coarse count steps on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hitStrobe | input | 1 | One-cycle hit indication |
| hitChan | input | 5 | Channel number of the hit |
| hiResMode | input | 1 | 1 selects high resolution with interpolation, 0 selects low resolution |
| phaseIdx | input | 3 | Sampled phase of the multiplied clock |
| tapVec | input | 32 | Sampled delay-line thermometer vector; bit 0 is the first cell |
| interpBits | input | 2 | Sampled interpolation step |
| stampValid | output | 1 | High for one cycle when a new time word is presented |
| stamp | output | 22 | Time word {coarse, phase, tap, interpolation} |
| stampChan | output | 5 | Channel of the presented time word |
| stampHiRes | output | 1 | Resolution mode of the presented time word |

## Verification
The coarse counter's wrap and a hit capture can land in the same clock. In that case the stamp must carry the pre-increment value 4095, not the 0 that the counter takes at the same edge. The bench idles until the counter reaches 4095, fires strobes in that cycle and in the next, and expects 4095 and then 0. A behavioural model tracks the count independently and is compared on every clock. A second overlap is a mode switch arriving with a strobe on channel 8 or above. The bench provokes this by flipping `hiResMode` on the same cycle as such a strobe. It then judges that the outputs either hold their old values or report the new channel, according to the mode sampled with the strobe.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // load the output word this cycle
    logic hiRes;     // mode sampled with the hit
  } tsc_ctrl_t;
endpackage

// File: rtl/tsc_therm_decode.sv
module tsc_therm_decode #(
  parameter int TAPS  = 32,
  parameter int TAP_W = $clog2(TAPS)
) (
  input  logic [TAPS-1:0]  tapVec,
  output logic [TAP_W-1:0] tapIdx
);
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(TAPS - 1);

  // lowest zero wins; ones above it (bubbles) are ignored
  always_comb begin
    tapIdx = LAST_TAP;
    for (int i = TAPS - 1; i >= 0; i--) begin
      if (!tapVec[i]) tapIdx = TAP_W'(i);
    end
  end

  logic [TAPS-1:0] belowMask;
  always_comb belowMask = (TAPS'(1) << tapIdx) - TAPS'(1);

  // R3
  always_comb begin
    if (tapIdx != LAST_TAP) tap_zero_chk: assert (!tapVec[tapIdx]);
  end
  // R4
  always_comb begin
    tap_below_ones_chk: assert ((tapVec & belowMask) == belowMask);
  end
endmodule

// File: rtl/tsc_ctrl.sv
module tsc_ctrl
  import tsc_pkg::*;
#(
  parameter int LR_CHANNELS = 32,
  parameter int HR_CHANNELS = 8,
  parameter int CHAN_W      = $clog2(LR_CHANNELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hitStrobe,
  input  logic [CHAN_W-1:0] hitChan,
  input  logic              hiResMode,
  output tsc_ctrl_t         ctrl,
  output logic              stampValid
);
  localparam logic [CHAN_W:0] HR_LIM = (CHAN_W + 1)'(HR_CHANNELS);
  localparam logic [CHAN_W:0] LR_LIM = (CHAN_W + 1)'(LR_CHANNELS);

  logic chanOk;
  always_comb begin
    chanOk = hiResMode ? ({1'b0, hitChan} < HR_LIM) : ({1'b0, hitChan} < LR_LIM);
    ctrl.capture = hitStrobe && chanOk;
    ctrl.hiRes   = hiResMode;
  end

  always_ff @(posedge clk) begin
    if (rst) stampValid <= 1'b0;
    else     stampValid <= ctrl.capture;
  end

  // R9
  valid_after_hit_chk: assert property (@(posedge clk) disable iff (rst)
    stampValid |-> $past(hitStrobe));
  // R7
  hr_chan_range_chk: assert property (@(posedge clk) disable iff (rst)
    (hitStrobe && hiResMode && ({1'b0, hitChan} >= HR_LIM)) |=> !stampValid);
endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath
  import tsc_pkg::*;
#(
  parameter int COARSE_W = 12,
  parameter int PHASE_W  = 3,
  parameter int TAPS     = 32,
  parameter int INTERP_W = 2,
  parameter int CHAN_W   = 5,
  parameter int TAP_W    = $clog2(TAPS),
  parameter int STAMP_W  = COARSE_W + PHASE_W + TAP_W + INTERP_W
) (
  input  logic                clk,
  input  logic                rst,
  input  tsc_ctrl_t           ctrl,
  input  logic [PHASE_W-1:0]  phaseIdx,
  input  logic [TAPS-1:0]     tapVec,
  input  logic [INTERP_W-1:0] interpBits,
  input  logic [CHAN_W-1:0]   hitChan,
  output logic [STAMP_W-1:0]  stamp,
  output logic [CHAN_W-1:0]   stampChan,
  output logic                stampHiRes
);
  localparam int INTERP_LSB = 0;
  localparam int TAP_LSB    = INTERP_LSB + INTERP_W;
  localparam int PHASE_LSB  = TAP_LSB + TAP_W;
  localparam int COARSE_LSB = PHASE_LSB + PHASE_W;

  logic [COARSE_W-1:0] coarseCnt;
  logic [TAP_W-1:0]    tapIdx;
  logic [INTERP_W-1:0] interpSel;
  logic                live;

  tsc_therm_decode #(.TAPS(TAPS), .TAP_W(TAP_W)) u_dec (
    .tapVec(tapVec),
    .tapIdx(tapIdx)
  );

  always_comb interpSel = ctrl.hiRes ? interpBits : '0;

  // free-running coarse count; wraps naturally
  always_ff @(posedge clk) begin
    if (rst) begin
      coarseCnt <= '0;
      live      <= 1'b0;
    end else begin
      coarseCnt <= coarseCnt + 1'b1;
      live      <= 1'b1;
    end
  end

  // output word holds until the next accepted hit
  always_ff @(posedge clk) begin
    if (rst) begin
      stamp      <= '0;
      stampChan  <= '0;
      stampHiRes <= 1'b0;
    end else if (ctrl.capture) begin
      stamp      <= {coarseCnt, phaseIdx, tapIdx, interpSel};
      stampChan  <= hitChan;
      stampHiRes <= ctrl.hiRes;
    end
  end

  // R1
  coarse_step_chk: assert property (@(posedge clk) disable iff (rst)
    live |-> coarseCnt == COARSE_W'($past(coarseCnt) + 1'b1));
  // R10
  coarse_pre_inc_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.capture |=> stamp[COARSE_LSB +: COARSE_W] == COARSE_W'(coarseCnt - 1'b1));
  // R5
  lr_interp_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.capture && !ctrl.hiRes) |=> (stamp[INTERP_LSB +: INTERP_W] == '0) && !stampHiRes);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.capture |=> $stable(stamp) && $stable(stampChan));
endmodule

// File: rtl/tdc_stamp_top.sv
module tdc_stamp_top
  import tsc_pkg::*;
#(
  parameter int COARSE_W    = 12,
  parameter int PHASE_W     = 3,
  parameter int TAPS        = 32,
  parameter int INTERP_W    = 2,
  parameter int LR_CHANNELS = 32,
  parameter int HR_CHANNELS = 8,
  parameter int CHAN_W      = $clog2(LR_CHANNELS),
  parameter int TAP_W       = $clog2(TAPS),
  parameter int STAMP_W     = COARSE_W + PHASE_W + TAP_W + INTERP_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hitStrobe,
  input  logic [CHAN_W-1:0]   hitChan,
  input  logic                hiResMode,
  input  logic [PHASE_W-1:0]  phaseIdx,
  input  logic [TAPS-1:0]     tapVec,
  input  logic [INTERP_W-1:0] interpBits,
  output logic                stampValid,
  output logic [STAMP_W-1:0]  stamp,
  output logic [CHAN_W-1:0]   stampChan,
  output logic                stampHiRes
);
  tsc_ctrl_t ctrl;

  tsc_ctrl #(
    .LR_CHANNELS(LR_CHANNELS), .HR_CHANNELS(HR_CHANNELS), .CHAN_W(CHAN_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .hitStrobe(hitStrobe), .hitChan(hitChan),
    .hiResMode(hiResMode), .ctrl(ctrl), .stampValid(stampValid)
  );

  tsc_datapath #(
    .COARSE_W(COARSE_W), .PHASE_W(PHASE_W), .TAPS(TAPS), .INTERP_W(INTERP_W),
    .CHAN_W(CHAN_W), .TAP_W(TAP_W), .STAMP_W(STAMP_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .phaseIdx(phaseIdx), .tapVec(tapVec),
    .interpBits(interpBits), .hitChan(hitChan), .stamp(stamp),
    .stampChan(stampChan), .stampHiRes(stampHiRes)
  );
endmodule

// File: tb/sim_tdc_stamp_top.sv
module sim_tdc_stamp_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hitStrobe = 1'b0;
  logic [4:0]  hitChan = '0;
  logic        hiResMode = 1'b0;
  logic [2:0]  phaseIdx = '0;
  logic [31:0] tapVec = '0;
  logic [1:0]  interpBits = '0;
  logic        stampValid;
  logic [21:0] stamp;
  logic [4:0]  stampChan;
  logic        stampHiRes;

  tdc_stamp_top u0 (
    .clk(clk), .rst(rst), .hitStrobe(hitStrobe), .hitChan(hitChan),
    .hiResMode(hiResMode), .phaseIdx(phaseIdx), .tapVec(tapVec),
    .interpBits(interpBits), .stampValid(stampValid), .stamp(stamp),
    .stampChan(stampChan), .stampHiRes(stampHiRes)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int refCoarse = 0;
  logic [21:0] expStamp = '0;
  logic [4:0]  expChan = '0;
  logic        expHi = 1'b0;
  logic        expValid = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int refTap(input logic [31:0] v);
    for (int k = 0; k < 32; k++) if (v[k] == 1'b0) return k;
    return 31;
  endfunction

  // one clock: drive at negedge, model, compare at the next negedge
  task automatic step(input bit hit, input int ch, input bit hi, input int ph,
                      input logic [31:0] tv, input int ip, input string req);
    bit accept;
    hitStrobe = hit; hitChan = 5'(ch); hiResMode = hi;
    phaseIdx = 3'(ph); tapVec = tv; interpBits = 2'(ip);
    accept = hit && (hi ? (ch < 8) : (ch < 32));
    if (accept) begin
      expStamp = {12'(refCoarse), 3'(ph), 5'(refTap(tv)), hi ? 2'(ip) : 2'b00};
      expChan = 5'(ch);
      expHi = hi;
    end
    expValid = accept;
    @(posedge clk);
    refCoarse = (refCoarse + 1) % 4096;
    @(negedge clk);
    hitStrobe = 1'b0;
    chk(stampValid == expValid, {req, " valid"}, stampValid, expValid);
    chk(stamp == expStamp, {req, " stamp"}, stamp, expStamp);
    chk(stampChan == expChan, {req, " chan"}, stampChan, expChan);
    chk(stampHiRes == expHi, {req, " mode"}, stampHiRes, expHi);
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 32'h0, 0, req);
  endtask

  function automatic logic [31:0] therm(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(stampValid == 1'b0, "R11 valid", stampValid, 0);
    chk(stamp == '0, "R11 stamp", stamp, 0);
    chk(stampChan == '0 && stampHiRes == 1'b0, "R11 chan/mode", {stampChan, stampHiRes}, 0);
    rst = 1'b0;
    refCoarse = 0;

    // R1 R2 R3 low-res basics
    step(1, 3, 0, 5, therm(7), 3, "R1 R2 R3 R5");
    idle("R9 single cycle");
    // R3 end cases
    step(1, 0, 0, 0, 32'h0, 0, "R3 zero");
    step(1, 31, 0, 7, 32'hFFFF_FFFF, 1, "R3 full R8");
    step(1, 12, 0, 2, therm(31), 0, "R3 thirty-one");
    // R4 bubbles above the edge
    step(1, 4, 0, 1, therm(10) | 32'hF0F0_0000, 2, "R4 bubble");
    step(1, 5, 1, 6, therm(3) | 32'h0000_0010, 3, "R4 R6 bubble hr");
    // R6 high-res keeps interpolation
    step(1, 7, 1, 4, therm(20), 2, "R6");
    // R7 rejected channel, outputs hold
    step(1, 8, 1, 3, therm(5), 1, "R7 ch8");
    step(1, 31, 1, 3, therm(9), 1, "R7 ch31");
    // R8 same channels accepted in low res
    step(1, 8, 0, 3, therm(5), 1, "R8 ch8");
    // mode flips with an upper-channel hit
    step(1, 20, 1, 1, therm(1), 3, "R7 flip");
    step(1, 20, 0, 1, therm(1), 3, "R8 flip R5");
    // back-to-back hits
    step(1, 1, 1, 2, therm(2), 1, "R9 b2b");
    step(1, 2, 1, 3, therm(4), 2, "R9 b2b");

    // pseudo-random mix
    for (int i = 0; i < 300; i++) begin
      int n = $urandom_range(32);
      logic [31:0] tv = therm(n);
      if ($urandom_range(3) == 0 && n < 30) tv |= 32'(1) << (n + 1 + $urandom_range(30 - n));
      step($urandom_range(1), $urandom_range(31), $urandom_range(1), $urandom_range(7),
           tv, $urandom_range(3), "R1 R3 R4 R7 mix");
    end

    // R10 rollover with a capture on both sides of the wrap
    while (refCoarse != 4095) idle("R1 idle");
    step(1, 6, 1, 7, therm(16), 3, "R10 at 4095");
    step(1, 6, 0, 0, therm(16), 3, "R10 at 0");
    chk(stamp[21:10] == 12'd0, "R10 wrapped", stamp[21:10], 0);
    idle("R9 after wrap");

    finishRun();
  end
endmodule